// File: doc/BRIEF.md
# Condition Flag Register with Branch Resolution

This block holds the status flags of a small load/store processor and decides whether a conditional branch is taken. On each clock edge where the write strobe is high, it samples the ALU result word, the adder carry-out and the two compare operands, together with a two-bit operation class. Only the flag group that belongs to that class changes. The other groups keep their values, so a compare can be followed by logic operations and the branch that tests the compare outcome still sees it.

The flags sit in the low nine bits of a 32-bit word. Every bit from 9 upward reads as zero. A four-bit branch code picks one stored flag, and the taken signal follows combinationally from the registered word. A branch in the same cycle as a flag update therefore sees the value from before the update. The flags come in complementary pairs rather than sign and overflow bits: zero / non-zero, a separate equals-one flag, carry / no-carry, and less / greater / equal / not-equal for unsigned compares.

Top module: `cc_flag_reg`

## Requirements
- R1: The flag word changes only on a rising edge where `wr_en` is 1 and `op_class` is 1 (result op), 2 (add) or 3 (compare). With `wr_en` 0, or with class 0 (other), every bit holds its value.
- R2: A result op or an add writes bit 0 = (result == 0), bit 1 = (result == 1) and bit 2 = (result != 0).
- R3: An add writes bit 3 = carry-out and bit 4 = inverse of carry-out. No other class changes bits 3 and 4.
- R4: A compare treats both operands as unsigned. It writes bit 5 = (a < b), bit 6 = (a > b), bit 7 = (a == b) and bit 8 = (a != b), so exactly one of bits 5 to 7 is set.
- R5: Bits 31 down to 9 of `ccr_q` always read 0.
- R6: Flags outside the updating class's group hold their values. A compare leaves bits 0 to 4 unchanged, a result op leaves bits 3 to 8 unchanged, and an add leaves bits 5 to 8 unchanged.
- R7: While `rst_n` is low, the whole word is 0.
- R8: For `br_code` values 0 to 8, `br_taken` equals `ccr_q[br_code]`. That is: 0 zero, 1 equals-one, 2 non-zero, 3 carry, 4 no-carry, 5 less, 6 greater, 7 equal, 8 not-equal. Codes 9 to 15 are never taken.
- R9: `br_taken` is combinational from the registered flags. During a cycle in which an update is presented, it still reflects the flags from before that update.
- R10: After a compare of a smaller first operand with a larger second one, code 5 is taken and code 6 is not. With the operands swapped, code 6 is taken and code 5 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Flag update strobe |
| op_class | input | 2 | 0 other, 1 result op, 2 add, 3 compare |
| alu_result | input | 32 | ALU result word |
| alu_carry | input | 1 | Adder carry-out |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_code | input | 4 | Branch condition selector |
| ccr_q | output | 32 | Registered flag word |
| br_taken | output | 1 | Selected condition is true |

## Verification
On every cycle, the assertions check these invariants:
- the word holds when no update is issued;
- zero and non-zero are opposite after a result update;
- the carry pair is complementary after an add;
- exactly one compare relation is set, with not-equal as the inverse of equal;
- each class leaves the other groups untouched;
- unused branch codes are never taken.

The exact flag values need the bench's scenarios. These cover sweeps over edge-case result words and unsigned operand pairs across the signed boundary, the full branch decode for all sixteen codes after each update, and the pre-update value of the branch output while an update is pending.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [1:0] {
    OPC_OTHER  = 2'd0,
    OPC_RESULT = 2'd1,
    OPC_ADD    = 2'd2,
    OPC_CMP    = 2'd3
  } opc_e;

  // flag bit positions; branch code n selects bit n
  localparam int unsigned FL_ZERO = 0;
  localparam int unsigned FL_ONE  = 1;
  localparam int unsigned FL_NZ   = 2;
  localparam int unsigned FL_CY   = 3;
  localparam int unsigned FL_NCY  = 4;
  localparam int unsigned FL_LT   = 5;
  localparam int unsigned FL_GT   = 6;
  localparam int unsigned FL_EQ   = 7;
  localparam int unsigned FL_NE   = 8;
  localparam int unsigned FL_USED = 9;

  typedef struct packed {
    logic nz;
    logic one;
    logic zero;
  } res_flags_t;

  typedef struct packed {
    logic ncy;
    logic cy;
  } carry_flags_t;

  typedef struct packed {
    logic ne;
    logic eq;
    logic gt;
    logic lt;
  } cmp_flags_t;

endpackage

// File: rtl/ccr_result_flags.sv
module ccr_result_flags
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  output res_flags_t        res_f,
  output carry_flags_t      cy_f
);

  function automatic res_flags_t f_classify(input logic [DATA_W-1:0] v);
    res_flags_t r;
    r.zero = (v == '0);
    r.one  = (v == DATA_W'(1));
    r.nz   = |v;
    return r;
  endfunction

  function automatic carry_flags_t f_carry_pair(input logic c);
    carry_flags_t r;
    r.cy  = c;
    r.ncy = ~c;
    return r;
  endfunction

  always_comb begin
    res_f = f_classify(result);
    cy_f  = f_carry_pair(carry);
  end

endmodule

// File: rtl/ccr_compare.sv
module ccr_compare
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output cmp_flags_t        cmp_f
);

  function automatic cmp_flags_t f_relate(input logic [DATA_W-1:0] x,
                                          input logic [DATA_W-1:0] y);
    cmp_flags_t r;
    logic [DATA_W:0] diff;
    diff  = {1'b0, x} - {1'b0, y};
    r.lt  = diff[DATA_W];
    r.eq  = (diff[DATA_W-1:0] == '0);
    r.gt  = ~r.lt & ~r.eq;
    r.ne  = ~r.eq;
    return r;
  endfunction

  always_comb cmp_f = f_relate(a, b);

endmodule

// File: rtl/ccr_branch_eval.sv
module ccr_branch_eval
  import ccr_pkg::*;
#(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned NUM_COND = FL_USED
) (
  input  logic [NUM_COND-1:0] flags,
  input  logic [CODE_W-1:0]   code,
  output logic                taken
);

  localparam int unsigned NUM_CODES = 1 << CODE_W;

  logic [NUM_CODES-1:0] cond_vec;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CODES; gi++) begin : g_cond
      if (gi < NUM_COND) begin : g_used
        assign cond_vec[gi] = flags[gi];
      end else begin : g_unused
        assign cond_vec[gi] = 1'b0;
      end
    end
  endgenerate

  assign taken = cond_vec[code];

endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        op_class,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic [CODE_W-1:0] br_code,
  output logic [REG_W-1:0]  ccr_q,
  output logic              br_taken
);

  localparam int unsigned RSV_W = REG_W - FL_USED;

  opc_e         opc;
  res_flags_t   res_f;
  carry_flags_t cy_f;
  cmp_flags_t   cmp_f;
  logic         upd_res, upd_carry, upd_cmp, upd_any;
  logic [FL_USED-1:0] flags_q;

  assign opc       = opc_e'(op_class);
  assign upd_res   = wr_en && (opc == OPC_RESULT || opc == OPC_ADD);
  assign upd_carry = wr_en && (opc == OPC_ADD);
  assign upd_cmp   = wr_en && (opc == OPC_CMP);
  assign upd_any   = upd_res || upd_carry || upd_cmp;

  ccr_result_flags #(.DATA_W(DATA_W)) u_res (
    .result (alu_result),
    .carry  (alu_carry),
    .res_f  (res_f),
    .cy_f   (cy_f)
  );

  ccr_compare #(.DATA_W(DATA_W)) u_cmp (
    .a     (cmp_a),
    .b     (cmp_b),
    .cmp_f (cmp_f)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (upd_res)   flags_q[FL_NZ:FL_ZERO] <= res_f;
      if (upd_carry) flags_q[FL_NCY:FL_CY]  <= cy_f;
      if (upd_cmp)   flags_q[FL_NE:FL_LT]   <= cmp_f;
    end
  end

  assign ccr_q = {{RSV_W{1'b0}}, flags_q};

  ccr_branch_eval #(.CODE_W(CODE_W), .NUM_COND(FL_USED)) u_br (
    .flags (flags_q),
    .code  (br_code),
    .taken (br_taken)
  );

  // R1: no update issued -> whole word holds
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_any |=> $stable(ccr_q));

  // R2: zero and non-zero are opposite after a result update
  p_zero_nz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_res |=> (ccr_q[FL_ZERO] != ccr_q[FL_NZ]));

  // R3: carry pair complementary after an add
  p_carry_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_carry |=> (ccr_q[FL_CY] != ccr_q[FL_NCY]));

  // R4: exactly one relation, not-equal is inverse of equal
  p_cmp_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_cmp |=> ($countones(ccr_q[FL_EQ:FL_LT]) == 1 && ccr_q[FL_NE] != ccr_q[FL_EQ]));

  // R6: group retention per class
  p_cmp_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_cmp |=> $stable(ccr_q[FL_NCY:FL_ZERO]));
  p_res_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_res && !upd_carry) |=> $stable(ccr_q[FL_NE:FL_CY]));
  p_add_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_carry |=> $stable(ccr_q[FL_NE:FL_LT]));

  // R8: unused codes never taken
  p_unused_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(br_code) >= FL_USED) |-> !br_taken);

endmodule

// File: tb/cc_flag_reg_tb.sv
`timescale 1ns/1ps
module cc_flag_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  op_class = 2'd0;
  logic [31:0] alu_result = '0;
  logic        alu_carry = 1'b0;
  logic [31:0] cmp_a = '0;
  logic [31:0] cmp_b = '0;
  logic [3:0]  br_code = '0;
  logic [31:0] ccr_q;
  logic        br_taken;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q = '0;

  always #10 clk = ~clk;

  cc_flag_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_class(op_class),
    .alu_result(alu_result), .alu_carry(alu_carry),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .br_code(br_code),
    .ccr_q(ccr_q), .br_taken(br_taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // expected taken derived from R8 table
  function automatic logic exp_taken(input int code);
    return (code <= 8) ? exp_q[code] : 1'b0;
  endfunction

  task automatic check_all(input string req);
    chk({req, " R5/R2/R3/R4 word"}, ccr_q, exp_q);
    for (int c = 0; c < 16; c++) begin
      br_code = 4'(c);
      #0.25;
      chk({req, " R8 branch"}, {31'd0, br_taken}, {31'd0, exp_taken(c)});
    end
  endtask

  task automatic apply(input logic w, input logic [1:0] cls, input logic [31:0] res,
                       input logic cy, input logic [31:0] a, input logic [31:0] b,
                       input string req);
    @(negedge clk);
    wr_en = w; op_class = cls; alu_result = res; alu_carry = cy; cmp_a = a; cmp_b = b;
    // R9: pending update not visible on branch output
    br_code = (cls == 2'd3) ? 4'd7 : 4'd0;
    #1;
    chk("R9 pre-update branch", {31'd0, br_taken}, {31'd0, exp_taken(int'(br_code))});
    @(posedge clk);
    if (w) begin
      case (cls)
        2'd1: begin
          exp_q[0] = (res == 0); exp_q[1] = (res == 1); exp_q[2] = (res != 0);
        end
        2'd2: begin
          exp_q[0] = (res == 0); exp_q[1] = (res == 1); exp_q[2] = (res != 0);
          exp_q[3] = cy; exp_q[4] = !cy;
        end
        2'd3: begin
          exp_q[5] = (a < b); exp_q[6] = (a > b); exp_q[7] = (a == b); exp_q[8] = (a != b);
        end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    check_all(req);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [8];
    logic [31:0] lfsr;
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h2; vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000; vals[5] = 32'hFFFF_FFFF; vals[6] = 32'hFFFF_FFFE; vals[7] = 32'h0001_0000;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R7 reset");
    rst_n = 1'b1;

    // R2/R3/R6: result ops and adds over edge values
    for (int i = 0; i < 8; i++) begin
      apply(1'b1, 2'd2, vals[i], i[0], 32'd5, 32'd9, "R3 add");
      apply(1'b1, 2'd1, vals[7-i], 1'b0, 32'd5, 32'd9, "R2 R6 result op");
    end

    // R4/R6: unsigned compare sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        apply(1'b1, 2'd3, 32'hDEAD_0001, 1'b1, vals[i], vals[j], "R4 R6 compare");

    // R1: strobe low and class other are ignored
    apply(1'b0, 2'd3, 32'h0, 1'b1, 32'd1, 32'd0, "R1 strobe low");
    apply(1'b0, 2'd2, 32'h1, 1'b1, 32'd0, 32'd0, "R1 strobe low add");
    apply(1'b1, 2'd0, 32'h0, 1'b1, 32'd3, 32'd3, "R1 class other");

    // R10: ordering of compare operands
    apply(1'b1, 2'd3, 32'h0, 1'b0, 32'd1, 32'd2, "R10 smaller first");
    br_code = 4'd5; #0.25; chk("R10 less taken", {31'd0, br_taken}, 32'd1);
    br_code = 4'd6; #0.25; chk("R10 greater not taken", {31'd0, br_taken}, 32'd0);
    apply(1'b1, 2'd3, 32'h0, 1'b0, 32'd2, 32'd1, "R10 swapped");
    br_code = 4'd6; #0.25; chk("R10 greater taken", {31'd0, br_taken}, 32'd1);
    br_code = 4'd5; #0.25; chk("R10 less not taken", {31'd0, br_taken}, 32'd0);

    // pseudo-random mix
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[3], lfsr[1:0], (lfsr[7:4] == 0) ? 32'h0 : ((lfsr[7:4] == 1) ? 32'h1 : lfsr),
            lfsr[9], {28'd0, lfsr[13:10]}, {28'd0, lfsr[17:14]}, "R1 R6 mixed");
    end

    // R7: reset mid-run clears the word
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    exp_q = '0;
    check_all("R7 reset again");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule